// File: doc/BRIEF.md
# Line Overhead Error Monitor

This block sits behind the framer and parity checkers of an STS-1 or STS-3 receive path. Once per frame it is handed the extracted line-layer remote error byte, the B1 and B2 parity mismatch vectors and a one-cycle frame strobe. It keeps three saturating performance counters: remote line errors, B2 errors and B1 errors. Each counter can weigh a frame by the size of its error or simply note that the frame was errored.

An 8-bit control byte selects the counting mode of each counter. The same byte enables the signal-fail and signal-degrade monitors and drives a descrambler bypass output. Both monitors count B2 mismatched bits over a programmable window of frames. Each declares its defect when a window total reaches a set threshold and clears it when a window total falls below a separate, lower clear threshold. A disabled monitor keeps its current defect state.

Software reads a counter by selecting it and pulsing a read-and-clear strobe. The value appears on the read port one cycle later, and the counter restarts from zero without losing an increment that lands in the same cycle.

Top module: `line_oh_err_monitor`

## Requirements
- R1: With control bit 2 at 0, each frame strobe adds the value of the low four bits of the remote error byte to the remote error counter.
- R2: With control bit 2 at 1, each frame strobe adds one to the remote error counter when the low four bits are non-zero, and nothing otherwise.
- R3: With control bit 1 (B2) or bit 0 (B1) at 0, each frame strobe adds the number of set bits in that mismatch vector (24 bits for B2, 8 for B1) to its counter.
- R4: With control bit 1 or bit 0 at 1, each frame strobe adds one to that counter when its mismatch vector is non-zero.
- R5: The control byte resets to 0x00. Bit 6 is the signal-fail enable and bit 5 the signal-degrade enable. Bits 7 and 3 always read 0 and ignore writes. A write of value V reads back as V & 0x77.
- R6: The descrambler bypass output equals control bit 4 (0: descrambling active, 1: bypassed).
- R7: Counters are 16 bits and hold at 0xFFFF instead of wrapping.
- R8: The selector uses 0 for the remote error counter, 1 for B2 and 2 for B1, and 3 returns 0. On a read-and-clear strobe the read port shows the selected counter one cycle later. The counter then holds only the increment from the strobe cycle. The read port changes only after a strobe.
- R9: A monitor window spans the configured number of frames (0 acts as 1) and totals the B2 mismatched bits in every mode. When a window total reaches the set threshold, the defect is declared in the cycle after that window's last frame strobe.
- R10: A declared defect clears, in the cycle after the last strobe of a window, when that window total is below the clear threshold.
- R11: While a monitor's enable is 0 its defect output does not change.
- R12: Any control write restarts both monitor windows from frame zero with an empty total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe marking valid per-frame inputs |
| rei_byte | input | 8 | Extracted remote error byte; low nibble used |
| b1_mis | input | 8 | B1 parity mismatch vector |
| b2_mis | input | B2_W | B2 parity mismatch vector |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read-back |
| win_frames | input | WIN_W | Monitor window length in frames |
| sf_set_thr | input | THR_W | Signal-fail declare threshold |
| sf_clr_thr | input | THR_W | Signal-fail clear threshold |
| sd_set_thr | input | THR_W | Signal-degrade declare threshold |
| sd_clr_thr | input | THR_W | Signal-degrade clear threshold |
| cnt_sel | input | 2 | Counter selector for read-and-clear |
| cnt_rdclr | input | 1 | Read-and-clear strobe |
| cnt_rdata | output | CNT_W | Latched counter value |
| sf_defect | output | 1 | Signal-fail defect state |
| sd_defect | output | 1 | Signal-degrade defect state |
| descr_bypass | output | 1 | Descrambler bypass |

## Verification
A vector table drives single frames in mixed mode combinations. The remote error nibble ranges from zero to 15, B1 and B2 vectors have one, several or all bits set, and some vectors split their set bits across far-apart positions. This separates value weighting from per-frame weighting and shows that each control bit steers only its own counter. Directed cases then cover saturation after thousands of full-width B2 frames, and a read-and-clear strobe that coincides with a frame. The monitor windows are run with totals above both set thresholds, between the two clear thresholds (which separates the two monitors' hysteresis) and at zero, and again with the enables off to show the frozen state.

// File: rtl/loh_mon_pkg.sv
package loh_mon_pkg;

   typedef enum logic [1:0] {
      SEL_REI  = 2'd0,
      SEL_B2   = 2'd1,
      SEL_B1   = 2'd2,
      SEL_NONE = 2'd3
   } cnt_sel_e;

   typedef enum logic {
      TALLY_VALUE,
      TALLY_POP
   } tally_kind_e;

   localparam int CTL_B1_MODE   = 0;
   localparam int CTL_B2_MODE   = 1;
   localparam int CTL_REI_MODE  = 2;
   localparam int CTL_DESCR_OFF = 4;
   localparam int CTL_SD_EN     = 5;
   localparam int CTL_SF_EN     = 6;
   localparam logic [7:0] CTL_RW_MASK = 8'h77;

endpackage

// File: rtl/vec_popcount.sv
module vec_popcount #(
   parameter int IN_W  = 8,
   localparam int OUT_W = $clog2(IN_W + 1)
) (
   input  logic [IN_W-1:0]  vec,
   output logic [OUT_W-1:0] ones
);
   if (IN_W < 1) begin : g_bad_width
      $error("vec_popcount: IN_W must be at least 1");
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < IN_W; i++) begin
         ones = ones + OUT_W'(vec[i]);
      end
   end
endmodule

// File: rtl/err_tally.sv
module err_tally
   import loh_mon_pkg::*;
#(
   parameter int          IN_W  = 8,
   parameter int          CNT_W = 16,
   parameter tally_kind_e KIND  = TALLY_POP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_stb,
   input  logic              frame_mode,
   input  logic [IN_W-1:0]   err_vec,
   input  logic              rdclr,
   output logic [CNT_W-1:0]  cnt
);
   localparam int MAG_W = (KIND == TALLY_VALUE) ? IN_W : $clog2(IN_W + 1);

   if (MAG_W >= CNT_W) begin : g_bad_width
      $error("err_tally: per-frame magnitude must be narrower than the counter");
   end

   logic [CNT_W-1:0] mag;

   if (KIND == TALLY_VALUE) begin : g_value
      assign mag = CNT_W'(err_vec);
   end else begin : g_pop
      logic [MAG_W-1:0] ones;
      vec_popcount #(.IN_W(IN_W)) u_pop (
         .vec  (err_vec),
         .ones (ones)
      );
      assign mag = CNT_W'(ones);
   end

   logic [CNT_W-1:0] inc;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] sat;

   always_comb begin
      if (!frm_stb)        inc = '0;
      else if (frame_mode) inc = CNT_W'(|err_vec);
      else                 inc = mag;
      sum = {1'b0, cnt} + {1'b0, inc};
      sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (rdclr) cnt <= inc;
      else            cnt <= sat;
   end
endmodule

// File: rtl/defect_window.sv
module defect_window #(
   parameter int WIN_W = 12,
   parameter int ACC_W = 16,
   parameter int EB_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             frm_stb,
   input  logic [EB_W-1:0]  err_bits,
   input  logic             enable,
   input  logic [WIN_W-1:0] win_len,
   input  logic [ACC_W-1:0] set_thr,
   input  logic [ACC_W-1:0] clr_thr,
   output logic             defect
);
   if (EB_W >= ACC_W) begin : g_bad_width
      $error("defect_window: accumulator must be wider than per-frame bits");
   end

   logic [WIN_W-1:0] fcnt;
   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] total;
   logic             last;

   always_comb begin
      last  = ({1'b0, fcnt} + 1'b1) >= {1'b0, win_len};
      sum   = {1'b0, acc} + (ACC_W + 1)'(err_bits);
      total = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt   <= '0;
         acc    <= '0;
         defect <= 1'b0;
      end else if (restart) begin
         fcnt <= '0;
         acc  <= '0;
      end else if (frm_stb) begin
         if (last) begin
            fcnt <= '0;
            acc  <= '0;
            if (enable) begin
               if (!defect && total >= set_thr)     defect <= 1'b1;
               else if (defect && total < clr_thr)  defect <= 1'b0;
            end
         end else begin
            fcnt <= fcnt + 1'b1;
            acc  <= total;
         end
      end
   end
endmodule

// File: rtl/line_oh_err_monitor.sv
module line_oh_err_monitor
   import loh_mon_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int B2_W  = 24,
   parameter int WIN_W = 12,
   parameter int THR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_stb,
   input  logic [7:0]       rei_byte,
   input  logic [7:0]       b1_mis,
   input  logic [B2_W-1:0]  b2_mis,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic [WIN_W-1:0] win_frames,
   input  logic [THR_W-1:0] sf_set_thr,
   input  logic [THR_W-1:0] sf_clr_thr,
   input  logic [THR_W-1:0] sd_set_thr,
   input  logic [THR_W-1:0] sd_clr_thr,
   input  logic [1:0]       cnt_sel,
   input  logic             cnt_rdclr,
   output logic [CNT_W-1:0] cnt_rdata,
   output logic             sf_defect,
   output logic             sd_defect,
   output logic             descr_bypass
);
   localparam int B2_POP_W = $clog2(B2_W + 1);

   if (B2_W != 8 && B2_W != 24) begin : g_bad_b2
      $error("line_oh_err_monitor: B2_W must be 8 (STS-1) or 24 (STS-3)");
   end
   if (CNT_W < 8) begin : g_bad_cnt
      $error("line_oh_err_monitor: CNT_W must be at least 8");
   end

   // control byte
   logic [7:0] ctl_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_wdata & CTL_RW_MASK;
   end
   assign ctl_rdata    = ctl_q;
   assign descr_bypass = ctl_q[CTL_DESCR_OFF];

   logic unused_rei_hi;
   assign unused_rei_hi = ^rei_byte[7:4];

   // per-counter clear strobes
   logic clr_rei, clr_b2, clr_b1;
   assign clr_rei = cnt_rdclr && (cnt_sel == SEL_REI);
   assign clr_b2  = cnt_rdclr && (cnt_sel == SEL_B2);
   assign clr_b1  = cnt_rdclr && (cnt_sel == SEL_B1);

   logic [CNT_W-1:0] rei_cnt, b2_cnt, b1_cnt;

   err_tally #(.IN_W(4), .CNT_W(CNT_W), .KIND(TALLY_VALUE)) u_rei (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_stb    (frm_stb),
      .frame_mode (ctl_q[CTL_REI_MODE]),
      .err_vec    (rei_byte[3:0]),
      .rdclr      (clr_rei),
      .cnt        (rei_cnt)
   );

   err_tally #(.IN_W(B2_W), .CNT_W(CNT_W), .KIND(TALLY_POP)) u_b2 (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_stb    (frm_stb),
      .frame_mode (ctl_q[CTL_B2_MODE]),
      .err_vec    (b2_mis),
      .rdclr      (clr_b2),
      .cnt        (b2_cnt)
   );

   err_tally #(.IN_W(8), .CNT_W(CNT_W), .KIND(TALLY_POP)) u_b1 (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_stb    (frm_stb),
      .frame_mode (ctl_q[CTL_B1_MODE]),
      .err_vec    (b1_mis),
      .rdclr      (clr_b1),
      .cnt        (b1_cnt)
   );

   // read port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_rdata <= '0;
      end else if (cnt_rdclr) begin
         unique case (cnt_sel)
            SEL_REI: cnt_rdata <= rei_cnt;
            SEL_B2:  cnt_rdata <= b2_cnt;
            SEL_B1:  cnt_rdata <= b1_cnt;
            default: cnt_rdata <= '0;
         endcase
      end
   end

   // defect monitors share one B2 bit count
   logic [B2_POP_W-1:0] b2_ones;
   vec_popcount #(.IN_W(B2_W)) u_b2_pop (
      .vec  (b2_mis),
      .ones (b2_ones)
   );

   for (genvar g = 0; g < 2; g++) begin : g_mon
      localparam bit IS_SF = (g == 0);
      logic             en;
      logic [THR_W-1:0] set_t, clr_t;
      logic             dout;
      assign en    = IS_SF ? ctl_q[CTL_SF_EN] : ctl_q[CTL_SD_EN];
      assign set_t = IS_SF ? sf_set_thr : sd_set_thr;
      assign clr_t = IS_SF ? sf_clr_thr : sd_clr_thr;
      defect_window #(.WIN_W(WIN_W), .ACC_W(THR_W), .EB_W(B2_POP_W)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .restart  (ctl_wr),
         .frm_stb  (frm_stb),
         .err_bits (b2_ones),
         .enable   (en),
         .win_len  (win_frames),
         .set_thr  (set_t),
         .clr_thr  (clr_t),
         .defect   (dout)
      );
   end
   assign sf_defect = g_mon[0].dout;
   assign sd_defect = g_mon[1].dout;
endmodule

// File: rtl/line_oh_err_monitor_chk.sv
module line_oh_err_monitor_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_stb,
   input logic             ctl_wr,
   input logic [7:0]       ctl_wdata,
   input logic [7:0]       ctl_rdata,
   input logic [1:0]       cnt_sel,
   input logic             cnt_rdclr,
   input logic [CNT_W-1:0] cnt_rdata,
   input logic             sf_defect,
   input logic             sd_defect,
   input logic             descr_bypass
);
   // R5
   ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr) |-> ctl_rdata == ($past(ctl_wdata) & 8'h77));

   // R6
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr) |-> descr_bypass == $past(ctl_wdata[4]));

   // R11
   sf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_rdata[6]) |-> $stable(sf_defect));

   // R11
   sd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_rdata[5]) |-> $stable(sd_defect));

   // R9
   defect_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_defect != $past(sf_defect) || sd_defect != $past(sd_defect)) |-> $past(frm_stb));

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rdata != $past(cnt_rdata)) |-> $past(cnt_rdclr));

   // R8
   rdclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_rdclr) && $past(cnt_rdclr, 2) && !$past(frm_stb, 2)
       && $past(cnt_sel) == $past(cnt_sel, 2)) |-> cnt_rdata == '0);
endmodule

bind line_oh_err_monitor line_oh_err_monitor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frm_stb      (frm_stb),
   .ctl_wr       (ctl_wr),
   .ctl_wdata    (ctl_wdata),
   .ctl_rdata    (ctl_rdata),
   .cnt_sel      (cnt_sel),
   .cnt_rdclr    (cnt_rdclr),
   .cnt_rdata    (cnt_rdata),
   .sf_defect    (sf_defect),
   .sd_defect    (sd_defect),
   .descr_bypass (descr_bypass)
);

// File: tb/line_oh_err_monitor_test.sv
module line_oh_err_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_stb = 1'b0;
   logic [7:0]  rei_byte = '0;
   logic [7:0]  b1_mis = '0;
   logic [23:0] b2_mis = '0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic [11:0] win_frames = 12'd4;
   logic [15:0] sf_set_thr = 16'd10;
   logic [15:0] sf_clr_thr = 16'd3;
   logic [15:0] sd_set_thr = 16'd4;
   logic [15:0] sd_clr_thr = 16'd2;
   logic [1:0]  cnt_sel = '0;
   logic        cnt_rdclr = 1'b0;
   logic [15:0] cnt_rdata;
   logic        sf_defect, sd_defect, descr_bypass;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   line_oh_err_monitor uut (
      .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .rei_byte(rei_byte),
      .b1_mis(b1_mis), .b2_mis(b2_mis), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .win_frames(win_frames), .sf_set_thr(sf_set_thr),
      .sf_clr_thr(sf_clr_thr), .sd_set_thr(sd_set_thr), .sd_clr_thr(sd_clr_thr),
      .cnt_sel(cnt_sel), .cnt_rdclr(cnt_rdclr), .cnt_rdata(cnt_rdata),
      .sf_defect(sf_defect), .sd_defect(sd_defect), .descr_bypass(descr_bypass)
   );

   typedef struct packed {
      logic [7:0]  ctl;
      logic [7:0]  rei;
      logic [7:0]  b1;
      logic [23:0] b2;
      logic [15:0] e_rei;
      logic [15:0] e_b2;
      logic [15:0] e_b1;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      '{8'h00, 8'h35, 8'hFF, 24'h000001, 16'd5,  16'd1,  16'd8},
      '{8'h07, 8'h35, 8'hFF, 24'h000000, 16'd1,  16'd0,  16'd1},
      '{8'h00, 8'hF0, 8'h00, 24'hFFFFFF, 16'd0,  16'd24, 16'd0},
      '{8'h07, 8'hF0, 8'h00, 24'hFFFFFF, 16'd0,  16'd1,  16'd0},
      '{8'h04, 8'h0F, 8'h81, 24'h030000, 16'd1,  16'd2,  16'd2},
      '{8'h03, 8'h0F, 8'h81, 24'h800001, 16'd15, 16'd1,  16'd1},
      '{8'h02, 8'h0A, 8'h10, 24'h0F0F0F, 16'd10, 16'd1,  16'd1},
      '{8'h05, 8'h0C, 8'h77, 24'h000000, 16'd1,  16'd0,  16'd1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic frame(input logic [7:0] r, input logic [7:0] b1, input logic [23:0] b2);
      @(negedge clk);
      rei_byte = r; b1_mis = b1; b2_mis = b2; frm_stb = 1'b1;
      @(negedge clk);
      frm_stb = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] v);
      @(negedge clk);
      cnt_sel = sel; cnt_rdclr = 1'b1;
      @(negedge clk);
      cnt_rdclr = 1'b0;
      v = cnt_rdata;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R5, R6, R8, R9)
      check("R5 ctl reset", ctl_rdata, 8'h00);
      check("R6 bypass reset", descr_bypass, 1'b0);
      check("R8 rdata reset", cnt_rdata, 16'h0);
      check("R9 sf reset", sf_defect, 1'b0);
      check("R9 sd reset", sd_defect, 1'b0);

      // vector table: R1 R2 R3 R4
      for (int i = 0; i < NVEC; i++) begin
         rd(2'd0, v); rd(2'd1, v); rd(2'd2, v);
         wr_ctl(VEC[i].ctl);
         frame(VEC[i].rei, VEC[i].b1, VEC[i].b2);
         rd(2'd0, v); check(VEC[i].ctl[2] ? "R2 rei frame" : "R1 rei value", v, VEC[i].e_rei);
         rd(2'd1, v); check(VEC[i].ctl[1] ? "R4 b2 frame" : "R3 b2 bits", v, VEC[i].e_b2);
         rd(2'd2, v); check(VEC[i].ctl[0] ? "R4 b1 frame" : "R3 b1 bits", v, VEC[i].e_b1);
      end

      // R5 unused bits, R6 bypass
      wr_ctl(8'hFF);
      check("R5 masked readback", ctl_rdata, 8'h77);
      check("R6 bypass set", descr_bypass, 1'b1);
      wr_ctl(8'h88);
      check("R5 unused only", ctl_rdata, 8'h00);
      check("R6 bypass clear", descr_bypass, 1'b0);

      // R8 selector 3 returns zero
      rd(2'd3, v);
      check("R8 sel none", v, 16'h0);

      // R7 saturation: 2800 frames of 24 bits exceeds 65535
      rd(2'd1, v);
      for (int k = 0; k < 2800; k++) frame(8'h00, 8'h00, 24'hFFFFFF);
      rd(2'd1, v);
      check("R7 saturate", v, 16'hFFFF);
      rd(2'd1, v);
      check("R8 cleared after read", v, 16'h0);

      // R8 read-and-clear coinciding with a frame
      rd(2'd2, v);
      frame(8'h00, 8'h01, 24'h0);
      @(negedge clk);
      rei_byte = 8'h00; b1_mis = 8'h03; b2_mis = 24'h0;
      frm_stb = 1'b1; cnt_sel = 2'd2; cnt_rdclr = 1'b1;
      @(negedge clk);
      frm_stb = 1'b0; cnt_rdclr = 1'b0;
      check("R8 latched pre-frame value", cnt_rdata, 16'd1);
      rd(2'd2, v);
      check("R8 kept coinciding increment", v, 16'd2);

      // R9 R10 R12: enable both, window of 4 frames
      wr_ctl(8'h60);
      frame(8'h00, 8'h00, 24'h000007);
      frame(8'h00, 8'h00, 24'h000007);
      frame(8'h00, 8'h00, 24'h000007);
      check("R9 sf not before window end", sf_defect, 1'b0);
      frame(8'h00, 8'h00, 24'h000007);
      check("R9 sf declared", sf_defect, 1'b1);
      check("R9 sd declared", sd_defect, 1'b1);
      frame(8'h00, 8'h00, 24'h000001);
      frame(8'h00, 8'h00, 24'h000100);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      check("R10 sf cleared below 3", sf_defect, 1'b0);
      check("R10 sd held at 2", sd_defect, 1'b1);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      check("R10 sd cleared", sd_defect, 1'b0);

      // R12: restart realigns window; partial frames discarded
      frame(8'h00, 8'h00, 24'hFFFFFF);
      frame(8'h00, 8'h00, 24'hFFFFFF);
      wr_ctl(8'h60);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      check("R12 restart discards old total", sf_defect, 1'b0);
      frame(8'h00, 8'h00, 24'h0);
      frame(8'h00, 8'h00, 24'h0);
      check("R12 window realigned", sd_defect, 1'b0);

      // R11: enables off freeze state
      wr_ctl(8'h00);
      for (int k = 0; k < 4; k++) frame(8'h00, 8'h00, 24'h000007);
      check("R11 sf frozen low", sf_defect, 1'b0);
      check("R11 sd frozen low", sd_defect, 1'b0);
      wr_ctl(8'h40);
      for (int k = 0; k < 4; k++) frame(8'h00, 8'h00, 24'h000007);
      check("R11 sf enabled declares", sf_defect, 1'b1);
      check("R11 sd disabled stays", sd_defect, 1'b0);
      wr_ctl(8'h00);
      for (int k = 0; k < 4; k++) frame(8'h00, 8'h00, 24'h0);
      check("R11 sf frozen high", sf_defect, 1'b1);

      finish_run();
   end
endmodule